// File: doc/BRIEF.md
# Programmable Video Window Pulse Generator

This block produces a write-enable pulse for a video field memory. A free-running horizontal pixel counter restarts on every line reference pulse, and a vertical line counter restarts on every field reference pulse. The enable is high only when both counters fall inside a window that firmware has set up.

Firmware sets the window through an 8-bit register port. Horizontal edges are given as coarse values counted in units of two clocks, or four clocks when a mode bit is set. A 2-bit fine delay then moves both horizontal edges later by zero to three clocks. Vertical edges are given in whole lines. Every written value goes into a shadow copy first. That copy is moved into the working set only when a line reference pulse arrives, so no line ever sees half of an old setting and half of a new one.

Top module: `vwin_pulse_gen`

## Requirements
- R1: With the step mode bit at 0, a coarse value c marks horizontal position 2*c. Position p is the p-th clock after the cycle in which the line reference pulse is high, the first such clock being position 0. With fine delay 0, `h_pulse_o` is high at positions p where start <= p < stop.
- R2: With the step mode bit at 1, a coarse value c marks horizontal position 4*c.
- R3: Fine delay d (0 to 3) moves both edges of `h_pulse_o` d clocks later. The pulse is then high at positions start+d up to, but not including, stop+d.
- R4: The line counter is cleared by `field_ref_i` and increases by one on each `line_ref_i`. `v_win_o` is high while vstart <= line count < vstop.
- R5: `wen_o` is high exactly when `h_pulse_o` and `v_win_o` are both high.
- R6: `line_ref_i` clears the horizontal counter on the next clock.
- R7: Register writes use `cfg_addr_i`/`cfg_wdata_i` qualified by `cfg_we_i`:
  - address 0: horizontal start coarse value
  - address 1: horizontal stop coarse value
  - address 2: vertical start bits 7:0
  - address 3: vertical stop bits 7:0
  - address 4: bits 1:0 carry vertical start bits 9:8, bits 3:2 carry vertical stop bits 9:8
  - address 5: bit 0 is the step mode, bits 2:1 are the fine delay

  A write takes effect only from the next `line_ref_i`. The line in progress is not changed.
- R8: A start that is equal to or greater than its stop gives a window that stays low for the whole line or field.
- R9: After reset all settings are zero and all outputs are low.
- R10: Writes to addresses 6 and 7 change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_ref_i | input | 1 | Line reference pulse; restarts the horizontal count and applies pending settings |
| field_ref_i | input | 1 | Field reference pulse; restarts the line count |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| h_pulse_o | output | 1 | Horizontal window after the fine delay |
| v_win_o | output | 1 | Vertical line window |
| wen_o | output | 1 | Combined memory write enable |

## Verification
The bound checker watches several properties on every cycle:
- the horizontal counter clears after a line reference, and the line counter clears after a field reference;
- the working settings stay frozen between line references;
- the enable is gated by both windows;
- an inverted vertical window stays low;
- with zero fine delay, a rising horizontal edge lands only on a multiple of the selected step.

Other behaviours can only be shown by the directed scenarios:
- the exact pulse positions for each step mode and fine delay;
- the line numbering of the vertical window;
- a mid-line write leaving the current line untouched;
- writes to unmapped addresses being ignored.

// File: rtl/vwin_pkg.sv
package vwin_pkg;

    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int COARSE_W  = 8;
    localparam int HCNT_W    = 11;
    localparam int VCNT_W    = 10;
    localparam int FINE_W    = 2;
    localparam int VHI_W     = VCNT_W - DATA_W;
    localparam int FINE_TAPS = (1 << FINE_W) - 1;

    localparam logic [ADDR_W-1:0] ADR_HSTART = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_HSTOP  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_VSTLO  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_VSPLO  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_VHI    = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd5;

    typedef struct packed {
        logic [COARSE_W-1:0] h_start;
        logic [COARSE_W-1:0] h_stop;
        logic [VCNT_W-1:0]   v_start;
        logic [VCNT_W-1:0]   v_stop;
        logic                step4;
        logic [FINE_W-1:0]   fine;
    } cfg_t;

    function automatic logic [HCNT_W-1:0] coarse_pos(input logic [COARSE_W-1:0] c,
                                                     input logic step4);
        return step4 ? (HCNT_W'(c) << 2) : (HCNT_W'(c) << 1);
    endfunction

endpackage

// File: rtl/vwin_cfg_regs.sv
module vwin_cfg_regs
    import vwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              line_ref,
    output cfg_t              act
);
    cfg_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (we) begin
            case (addr)
                ADR_HSTART: shadow.h_start <= wdata;
                ADR_HSTOP:  shadow.h_stop  <= wdata;
                ADR_VSTLO:  shadow.v_start[DATA_W-1:0] <= wdata;
                ADR_VSPLO:  shadow.v_stop[DATA_W-1:0]  <= wdata;
                ADR_VHI: begin
                    shadow.v_start[VCNT_W-1:DATA_W] <= wdata[VHI_W-1:0];
                    shadow.v_stop[VCNT_W-1:DATA_W]  <= wdata[2*VHI_W-1:VHI_W];
                end
                ADR_CTRL: begin
                    shadow.step4 <= wdata[0];
                    shadow.fine  <= wdata[FINE_W:1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           act <= '0;
        else if (line_ref) act <= shadow;
    end
endmodule

// File: rtl/vwin_hwin.sv
module vwin_hwin
    import vwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_ref,
    input  cfg_t              act,
    output logic [HCNT_W-1:0] hcnt,
    output logic              h_pulse
);
    logic [HCNT_W-1:0]    hs_pos;
    logic [HCNT_W-1:0]    he_pos;
    logic                 raw;
    logic [FINE_TAPS-1:0] dly;
    logic [FINE_TAPS:0]   taps;

    always_ff @(posedge clk) begin
        if (rst || line_ref)  hcnt <= '0;
        else if (hcnt != '1) hcnt <= hcnt + 1'b1;
    end

    always_comb begin
        hs_pos = coarse_pos(act.h_start, act.step4);
        he_pos = coarse_pos(act.h_stop, act.step4);
        raw    = (hcnt >= hs_pos) && (hcnt < he_pos);
    end

    always_ff @(posedge clk) begin
        if (rst) dly <= '0;
        else     dly <= {dly[FINE_TAPS-2:0], raw};
    end

    assign taps    = {dly, raw};
    assign h_pulse = taps[act.fine];
endmodule

// File: rtl/vwin_vwin.sv
module vwin_vwin
    import vwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_ref,
    input  logic              field_ref,
    input  cfg_t              act,
    output logic [VCNT_W-1:0] vcnt,
    output logic              v_win
);
    always_ff @(posedge clk) begin
        if (rst || field_ref)                vcnt <= '0;
        else if (line_ref && vcnt != '1)     vcnt <= vcnt + 1'b1;
    end

    assign v_win = (vcnt >= act.v_start) && (vcnt < act.v_stop);
endmodule

// File: rtl/vwin_pulse_gen.sv
module vwin_pulse_gen
    import vwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_ref_i,
    input  logic              field_ref_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic              h_pulse_o,
    output logic              v_win_o,
    output logic              wen_o
);
    cfg_t              act_cfg;
    logic [HCNT_W-1:0] h_cnt;
    logic [VCNT_W-1:0] v_cnt;

    vwin_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we_i),
        .addr     (cfg_addr_i),
        .wdata    (cfg_wdata_i),
        .line_ref (line_ref_i),
        .act      (act_cfg)
    );

    vwin_hwin u_h (
        .clk      (clk),
        .rst      (rst),
        .line_ref (line_ref_i),
        .act      (act_cfg),
        .hcnt     (h_cnt),
        .h_pulse  (h_pulse_o)
    );

    vwin_vwin u_v (
        .clk       (clk),
        .rst       (rst),
        .line_ref  (line_ref_i),
        .field_ref (field_ref_i),
        .act       (act_cfg),
        .vcnt      (v_cnt),
        .v_win     (v_win_o)
    );

    assign wen_o = h_pulse_o & v_win_o;
endmodule

// File: rtl/vwin_chk.sv
module vwin_chk
    import vwin_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              line_ref,
    input logic              field_ref,
    input cfg_t              act,
    input logic [HCNT_W-1:0] hcnt,
    input logic [VCNT_W-1:0] vcnt,
    input logic              h_pulse,
    input logic              v_win,
    input logic              wen
);
    assert_hcnt_clear_R6: assert property (@(posedge clk) disable iff (rst)
        line_ref |=> (hcnt == '0));

    assert_vcnt_clear_R4: assert property (@(posedge clk) disable iff (rst)
        field_ref |=> (vcnt == '0));

    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !line_ref |=> $stable(act));

    assert_and_gate_R5: assert property (@(posedge clk) disable iff (rst)
        wen |-> (h_pulse && v_win));

    assert_empty_vwin_R8: assert property (@(posedge clk) disable iff (rst)
        (act.v_start >= act.v_stop) |-> !v_win);

    assert_step2_align_R1: assert property (@(posedge clk) disable iff (rst)
        (act.fine == '0 && !act.step4 && $rose(h_pulse)) |-> (hcnt[0] == 1'b0));

    assert_step4_align_R2: assert property (@(posedge clk) disable iff (rst)
        (act.fine == '0 && act.step4 && $rose(h_pulse)) |-> (hcnt[1:0] == 2'b00));
endmodule

bind vwin_pulse_gen vwin_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .line_ref  (line_ref_i),
    .field_ref (field_ref_i),
    .act       (act_cfg),
    .hcnt      (h_cnt),
    .vcnt      (v_cnt),
    .h_pulse   (h_pulse_o),
    .v_win     (v_win_o),
    .wen       (wen_o)
);

// File: tb/sim_vwin_pulse_gen.sv
module sim_vwin_pulse_gen;
    localparam int PERIOD   = 10;
    localparam int LINE_LEN = 120;
    localparam int WDOG     = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_ref = 1'b0;
    logic       field_ref = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       h_pulse, v_win, wen;

    int checks = 0;
    int failures = 0;
    logic hp [LINE_LEN];
    logic wn [LINE_LEN];
    logic vw;

    always #(PERIOD/2) clk = ~clk;

    vwin_pulse_gen u0 (
        .clk         (clk),
        .rst         (rst),
        .line_ref_i  (line_ref),
        .field_ref_i (field_ref),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .h_pulse_o   (h_pulse),
        .v_win_o     (v_win),
        .wen_o       (wen)
    );

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_line(input int wr_at, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        line_ref = 1'b1;
        @(negedge clk);
        line_ref = 1'b0;
        for (int p = 0; p < LINE_LEN; p++) begin
            hp[p] = h_pulse;
            wn[p] = wen;
            if (p == 0) vw = v_win;
            cfg_we = (p == wr_at);
            cfg_addr = a; cfg_wdata = d;
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    task automatic field_pulse();
        @(negedge clk);
        field_ref = 1'b1;
        @(negedge clk);
        field_ref = 1'b0;
    endtask

    task automatic check_line(input string tag, input int s, input int e, input logic v);
        int bad_h = -1;
        int bad_w = -1;
        for (int p = 0; p < LINE_LEN; p++) begin
            logic eh = (p >= s) && (p < e);
            if (hp[p] !== eh && bad_h < 0) bad_h = p;
            if (wn[p] !== (eh & v) && bad_w < 0) bad_w = p;
        end
        checks += 3;
        if (bad_h >= 0) begin
            failures++;
            $display("FAIL %s h_pulse pos %0d actual=%b expected=%b", tag, bad_h, hp[bad_h],
                     (bad_h >= s) && (bad_h < e));
        end
        if (bad_w >= 0) begin
            failures++;
            $display("FAIL %s wen pos %0d actual=%b expected=%b", tag, bad_w, wn[bad_w],
                     ((bad_w >= s) && (bad_w < e)) & v);
        end
        if (vw !== v) begin
            failures++;
            $display("FAIL %s v_win actual=%b expected=%b", tag, vw, v);
        end
    endtask

    task automatic open_vertical();
        wr(3'd2, 8'h00);
        wr(3'd3, 8'hFF);
        wr(3'd4, 8'h0C);
    endtask

    task automatic t_reset();
        @(negedge clk);
        checks++;
        if (h_pulse !== 1'b0 || v_win !== 1'b0 || wen !== 1'b0) begin
            failures++;
            $display("FAIL R9 outputs after reset actual=%b%b%b expected=000", h_pulse, v_win, wen);
        end
        run_line(-1, 3'd0, 8'h00);
        check_line("R9 first line", 0, 0, 1'b0);
    endtask

    task automatic t_step2();
        wr(3'd0, 8'd10); wr(3'd1, 8'd20); wr(3'd5, 8'h00);
        open_vertical();
        run_line(-1, 3'd0, 8'h00);
        check_line("R1 R5 step2", 20, 40, 1'b1);
    endtask

    task automatic t_step4();
        wr(3'd5, 8'h01);
        run_line(-1, 3'd0, 8'h00);
        check_line("R2 step4", 40, 80, 1'b1);
    endtask

    task automatic t_fine();
        wr(3'd5, 8'h06);
        run_line(-1, 3'd0, 8'h00);
        check_line("R3 fine3 step2", 23, 43, 1'b1);
        wr(3'd5, 8'h03);
        run_line(-1, 3'd0, 8'h00);
        check_line("R3 fine1 step4", 41, 81, 1'b1);
    endtask

    task automatic t_empty();
        wr(3'd5, 8'h00);
        wr(3'd0, 8'd15); wr(3'd1, 8'd15);
        run_line(-1, 3'd0, 8'h00);
        check_line("R8 equal", 0, 0, 1'b1);
        wr(3'd0, 8'd30); wr(3'd1, 8'd12);
        run_line(-1, 3'd0, 8'h00);
        check_line("R8 inverted", 0, 0, 1'b1);
        wr(3'd0, 8'd10); wr(3'd1, 8'd20);
        wr(3'd2, 8'd5); wr(3'd3, 8'd5); wr(3'd4, 8'h00);
        run_line(-1, 3'd0, 8'h00);
        check_line("R8 vertical equal", 20, 40, 1'b0);
        open_vertical();
    endtask

    task automatic t_boundary();
        run_line(-1, 3'd0, 8'h00);
        check_line("R7 baseline", 20, 40, 1'b1);
        run_line(5, 3'd1, 8'd30);
        check_line("R7 mid-line write held", 20, 40, 1'b1);
        run_line(-1, 3'd0, 8'h00);
        check_line("R7 applied next line", 20, 60, 1'b1);
    endtask

    task automatic t_unmapped();
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        run_line(-1, 3'd0, 8'h00);
        check_line("R10 unmapped", 20, 60, 1'b1);
    endtask

    task automatic t_vert();
        wr(3'd1, 8'd20);
        wr(3'd2, 8'd2); wr(3'd3, 8'd4); wr(3'd4, 8'h00);
        field_pulse();
        for (int k = 1; k <= 5; k++) begin
            run_line(-1, 3'd0, 8'h00);
            check_line($sformatf("R4 R5 line %0d", k), 20, 40, (k >= 2) && (k < 4));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_step2();
        t_step4();
        t_fine();
        t_empty();
        t_boundary();
        t_unmapped();
        t_vert();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * WDOG);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule